// File: doc/BRIEF.md
# Device-to-Host Virtual Wire Group

This block keeps four one-bit virtual wires that device firmware drives toward the host, together with a per-wire flag that marks a wire whose value has not yet been sent. Firmware reaches it through two 32-bit registers: a configuration word that also shows the pending flags, and a states word. While any flag is set, the block asks an eSPI transmitter to send one message made of an index byte and a data byte. When the transmitter takes the message, the block clears the flags that message carried.

Each wire group can be returned to a programmed value by a rising edge on one of four reset inputs, which firmware selects. Such a load never creates a message by itself.

Top module: `vw_d2h_group`

## Requirements
- R1: After `rst_n` is released, the configuration word reads 0x00000002, the states word reads 0, and `tx_req_o` is low.
- R2: Configuration word layout: host index in bits 7:0, reset-input select in bits 9:8, load value in bits 15:12 (bit k for wire k), pending flags in bits 19:16 (bit 16+k for wire k). All other bits read 0. Writes into bits 19:16 have no effect.
- R3: A host index written below 2 is stored as 2; the index presented with a message is never below 2.
- R4: States word layout: wire k is at bit 8*k (1 means the wire is one); all other bits read 0.
- R5: A write to the states word (`reg_sel_i`=1) updates all four wires on the next clock and sets the pending flag of each wire whose new value differs from its current value. Writing an unchanged value sets no flag. Without a write or a load the wires keep their values.
- R6: `tx_req_o` is high exactly when any pending flag is set; `tx_index_o` equals the host index; `tx_data_o` has the pending flags in bits 7:4 and the current wire values in bits 3:0.
- R7: A cycle with `tx_req_o` and `tx_ack_i` both high clears the flags shown in that message; a states write in the same cycle sets again the flags of the wires it changes. `tx_ack_i` while `tx_req_o` is low, and any cycle without acceptance, clears no flag.
- R8: The reset-input select picks `grp_rst_i[0..3]` by value 0..3. A rising edge (low in the previous cycle, high now) on the selected input loads the load value into the wires at that clock and clears all pending flags, setting none. It takes priority over a same-cycle states write and acceptance. An input already high when `rst_n` is released is not a rising edge.
- R9: Rising edges on reset inputs that are not selected change neither wires nor flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| grp_rst_i | input | 4 | Candidate group reset inputs, one per select value |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 configuration, 1 states |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| tx_req_o | output | 1 | Message pending toward the transmitter |
| tx_index_o | output | 8 | Index byte of the message |
| tx_data_o | output | 8 | Data byte: flags in 7:4, wire values in 3:0 |
| tx_ack_i | input | 1 | Transmitter takes the presented message |

## Verification
The collisions that matter are a transmitter acceptance landing in the same cycle as a firmware states write, and a selected reset edge landing together with either of them. The bench provokes both directly with a write plus acceptance that changes a wire already pending, and a reset edge plus write, then lets random traffic repeat them many times. Each cycle is judged against a bench model that clears the carried flags first and then ORs in the newly changed wires, with the reset load overriding both.

// File: rtl/vw_d2h_pkg.sv
package vw_d2h_pkg;
  localparam int NW     = 4;          // wires per group
  localparam int SRC_W  = 2;          // width of the reset select field
  localparam int NRST   = 1 << SRC_W; // number of reset inputs
  localparam int STRIDE = 8;          // bit distance between wires in the states word

  typedef logic [NW-1:0] wires_t;

  // Pull the wire values out of a states word.
  function automatic wires_t states_from_word(logic [31:0] w);
    wires_t r;
    for (int k = 0; k < NW; k++) r[k] = w[k*STRIDE];
    return r;
  endfunction

  // Spread wire values back into a states word.
  function automatic logic [31:0] states_to_word(wires_t s);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < NW; k++) r[k*STRIDE] = s[k];
    return r;
  endfunction

  // Data byte: pending flags above, wire values below.
  function automatic logic [7:0] msg_byte(wires_t pend, wires_t s);
    return {pend, s};
  endfunction

  // Keep the host index at or above the floor.
  function automatic logic [7:0] clamp_idx(logic [7:0] v, logic [7:0] floor_v);
    return (v < floor_v) ? floor_v : v;
  endfunction

  // Configuration word assembly.
  function automatic logic [31:0] cfg_word(logic [7:0] idx, logic [SRC_W-1:0] src,
                                           wires_t ld, wires_t pend);
    logic [31:0] r;
    r        = '0;
    r[7:0]   = idx;
    r[9:8]   = src;
    r[15:12] = ld;
    r[19:16] = pend;
    return r;
  endfunction
endpackage

// File: rtl/vw_rst_edge.sv
module vw_rst_edge #(
  parameter int N  = 4,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  rst_in,
  input  logic [SW-1:0] sel,
  output logic          load
);
  logic [N-1:0] prev;
  logic [N-1:0] rise;

  // Held high in reset so an input already high at release is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= rst_in;
  end

  for (genvar g = 0; g < N; g++) begin : g_rise
    assign rise[g] = rst_in[g] & ~prev[g];
  end

  assign load = rise[sel];
endmodule

// File: rtl/vw_cfg_reg.sv
module vw_cfg_reg
  import vw_d2h_pkg::*;
#(
  parameter logic [7:0] MIN_IDX = 8'd2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [31:0]      wdata,
  output logic [7:0]       idx,
  output logic [SRC_W-1:0] src,
  output wires_t           ld_val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= MIN_IDX;
      src    <= '0;
      ld_val <= '0;
    end else if (wr) begin
      idx    <= clamp_idx(wdata[7:0], MIN_IDX);
      src    <= wdata[9:8];
      ld_val <= wdata[15:12];
    end
  end
endmodule

// File: rtl/vw_wire_bank.sv
module vw_wire_bank
  import vw_d2h_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  wires_t ld_val,
  input  logic   st_wr,
  input  wires_t st_new,
  input  logic   fire,
  output wires_t wires,
  output wires_t pend
);
  wires_t diff;
  wires_t carried;

  assign diff    = st_wr ? (st_new ^ wires) : '0;
  assign carried = fire ? pend : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wires <= '0;
      pend  <= '0;
    end else if (load) begin
      wires <= ld_val;
      pend  <= '0;
    end else begin
      if (st_wr) wires <= st_new;
      pend <= (pend & ~carried) | diff;
    end
  end
endmodule

// File: rtl/vw_d2h_group.sv
module vw_d2h_group
  import vw_d2h_pkg::*;
#(
  parameter logic [7:0] MIN_IDX = 8'd2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NRST-1:0] grp_rst_i,
  input  logic            reg_wr_i,
  input  logic            reg_sel_i,
  input  logic [31:0]     reg_wdata_i,
  output logic [31:0]     reg_rdata_o,
  output logic            tx_req_o,
  output logic [7:0]      tx_index_o,
  output logic [7:0]      tx_data_o,
  input  logic            tx_ack_i
);
  logic             cfg_wr;
  logic             st_wr;
  logic             tx_fire;
  logic             rst_load;
  logic [7:0]       idx;
  logic [SRC_W-1:0] src;
  wires_t           ld_val;
  wires_t           st_new;
  wires_t           wires;
  wires_t           pend;

  assign cfg_wr  = reg_wr_i & ~reg_sel_i;
  assign st_wr   = reg_wr_i &  reg_sel_i;
  assign st_new  = states_from_word(reg_wdata_i);
  assign tx_fire = tx_req_o & tx_ack_i;

  vw_cfg_reg #(.MIN_IDX(MIN_IDX)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(reg_wdata_i),
    .idx(idx), .src(src), .ld_val(ld_val)
  );

  vw_rst_edge #(.N(NRST), .SW(SRC_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .rst_in(grp_rst_i), .sel(src), .load(rst_load)
  );

  vw_wire_bank u_bank (
    .clk(clk), .rst_n(rst_n), .load(rst_load), .ld_val(ld_val),
    .st_wr(st_wr), .st_new(st_new), .fire(tx_fire),
    .wires(wires), .pend(pend)
  );

  assign tx_req_o    = |pend;
  assign tx_index_o  = idx;
  assign tx_data_o   = msg_byte(pend, wires);
  assign reg_rdata_o = reg_sel_i ? states_to_word(wires) : cfg_word(idx, src, ld_val, pend);
endmodule

// File: rtl/vw_d2h_group_chk.sv
module vw_d2h_group_chk
  import vw_d2h_pkg::*;
#(
  parameter logic [7:0] MIN_IDX = 8'd2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_load,
  input logic       st_wr,
  input logic       tx_fire,
  input wires_t     st_new,
  input wires_t     ld_val,
  input logic [7:0] tx_index_o,
  input logic [7:0] tx_data_o
);
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_load |=> (tx_data_o[3:0] == $past(ld_val)) && (tx_data_o[7:4] == 4'b0)); // R8

  AST_STATE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && !rst_load) |=> tx_data_o[3:0] == $past(st_new)); // R5

  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_wr && !rst_load) |=> $stable(tx_data_o[3:0])); // R5

  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fire && !st_wr && !rst_load) |=> tx_data_o[7:4] == 4'b0); // R7

  AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_fire && !rst_load) |=> ((tx_data_o[7:4] & $past(tx_data_o[7:4])) == $past(tx_data_o[7:4]))); // R7

  AST_INDEX_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    tx_index_o >= MIN_IDX); // R3
endmodule

bind vw_d2h_group vw_d2h_group_chk #(.MIN_IDX(MIN_IDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_load(rst_load), .st_wr(st_wr), .tx_fire(tx_fire),
  .st_new(st_new), .ld_val(ld_val), .tx_index_o(tx_index_o), .tx_data_o(tx_data_o)
);

// File: tb/tb_vw_d2h_group.sv
`timescale 1ns/100ps
module tb_vw_d2h_group;
  localparam real CLK_P = 4.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  grp_rst = '0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_req;
  logic [7:0]  tx_index;
  logic [7:0]  tx_data;
  logic        tx_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the visible state
  logic [7:0] m_idx = 8'd2;
  logic [1:0] m_src = '0;
  logic [3:0] m_ld = '0;
  logic [3:0] m_st = '0;
  logic [3:0] m_pend = '0;
  logic [3:0] m_prev = '1;

  always #(CLK_P/2) clk = ~clk;

  vw_d2h_group dut (
    .clk(clk), .rst_n(rst_n), .grp_rst_i(grp_rst),
    .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .tx_req_o(tx_req), .tx_index_o(tx_index), .tx_data_o(tx_data), .tx_ack_i(tx_ack)
  );

  function automatic logic [31:0] exp_cfg();
    logic [31:0] r = 32'h0;
    r = r | {24'h0, m_idx};
    r = r | ({30'h0, m_src} << 8);
    r = r | ({28'h0, m_ld} << 12);
    r = r | ({28'h0, m_pend} << 16);
    return r;
  endfunction

  function automatic logic [31:0] exp_states();
    return {7'h0, m_st[3], 7'h0, m_st[2], 7'h0, m_st[1], 7'h0, m_st[0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every output with the model; called between clock edges.
  task automatic chk_all();
    reg_sel = 1'b0; #0.2;
    chk("R2 configuration word", reg_rdata, exp_cfg());
    reg_sel = 1'b1; #0.2;
    chk("R4 states word", reg_rdata, exp_states());
    chk("R6 request", {31'h0, tx_req}, {31'h0, m_pend != 4'h0});
    chk("R6 index byte", {24'h0, tx_index}, {24'h0, m_idx});
    chk("R6 data byte", {24'h0, tx_data}, {24'h0, m_pend, m_st});
  endtask

  task automatic cyc(input logic wr, input logic sel, input logic [31:0] wd,
                     input logic ack, input logic [3:0] rs);
    logic fire, ld;
    logic [3:0] nw;
    @(negedge clk);
    chk_all();
    reg_wr = wr; reg_sel = sel; reg_wdata = wd; tx_ack = ack; grp_rst = rs;
    fire = ack && (m_pend != 4'h0);
    ld   = rs[m_src] && !m_prev[m_src];
    nw   = {wd[24], wd[16], wd[8], wd[0]};
    @(posedge clk); #0.5;
    reg_wr = 1'b0; tx_ack = 1'b0;
    m_prev = rs;
    if (ld) begin
      m_st = m_ld; m_pend = '0;
    end else begin
      if (fire) m_pend = '0;
      if (wr && sel) begin
        m_pend = m_pend | (nw ^ m_st);
        m_st = nw;
      end
    end
    if (wr && !sel) begin
      m_idx = (wd[7:0] < 8'd2) ? 8'd2 : wd[7:0];
      m_src = wd[9:8]; m_ld = wd[15:12];
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] rs;
    void'($urandom(32'd1729));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #0.5; m_prev = grp_rst;
    // R1 reset values
    @(negedge clk);
    reg_sel = 1'b0; #0.2; chk("R1 cfg after reset", reg_rdata, 32'h2);
    reg_sel = 1'b1; #0.2; chk("R1 states after reset", reg_rdata, 32'h0);
    chk("R1 no request", {31'h0, tx_req}, 32'h0);

    // R3 index below floor
    cyc(1, 0, 32'h0000_0000, 0, 4'h0);
    @(negedge clk); reg_sel = 0; #0.2; chk("R3 index clamped", reg_rdata, 32'h2);
    // R2 fields; flag bits written are ignored
    cyc(1, 0, 32'hFFFF_A255, 0, 4'h0);
    @(negedge clk); reg_sel = 0; #0.2; chk("R2 layout and flag write ignored", reg_rdata, 32'h0000_A255);
    // R5 write sets flags of changed wires
    cyc(1, 1, 32'h0100_0101, 0, 4'h0);
    @(negedge clk); chk("R5 flags after first write", {24'h0, tx_data}, 32'hBB);
    cyc(1, 1, 32'h0100_0101, 0, 4'h0);
    cyc(0, 0, 32'h0, 1, 4'h0);
    @(negedge clk); chk("R7 accept clears", {31'h0, tx_req}, 32'h0);
    cyc(1, 1, 32'h0100_0101, 0, 4'h0);
    @(negedge clk); chk("R5 same value sets no flag", {24'h0, tx_data}, 32'h0B);
    cyc(0, 0, 32'h0, 1, 4'h0);
    @(negedge clk); chk("R7 ack without request", {24'h0, tx_data}, 32'h0B);
    // R7 write and acceptance in one cycle
    cyc(1, 1, 32'h0000_0001, 0, 4'h0);
    cyc(1, 1, 32'h0001_0001, 1, 4'h0);
    @(negedge clk); chk("R7 same-cycle write re-sets", {24'h0, tx_data}, 32'h45);
    // R9 edge on unselected input (select is 2)
    cyc(0, 0, 32'h0, 0, 4'b0001);
    @(negedge clk); chk("R9 unselected edge ignored", {24'h0, tx_data}, 32'h45);
    // R8 selected edge together with a write and acceptance
    cyc(1, 1, 32'h0101_0101, 1, 4'b0101);
    @(negedge clk); chk("R8 load wins", {24'h0, tx_data}, 32'h0A);
    cyc(0, 0, 32'h0, 0, 4'b0101);
    @(negedge clk); chk("R8 level is not an edge", {24'h0, tx_data}, 32'h0A);
    cyc(0, 0, 32'h0, 0, 4'b0000);

    // random traffic
    rs = 4'h0;
    for (int i = 0; i < 600; i++) begin
      logic wr, sel, ack;
      logic [31:0] wd;
      wr  = ($urandom % 3) == 0;
      sel = $urandom % 4 != 0;
      wd  = $urandom;
      if (!sel && ($urandom % 4 == 0)) wd[7:0] = $urandom % 3;
      ack = $urandom % 2;
      if ($urandom % 5 == 0) rs = $urandom;
      cyc(wr, sel, wd, ack, rs);
    end
    @(negedge clk);
    chk_all();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule